// File: doc/BRIEF.md
# PCI Host Interrupt Status Aggregator

This block collects interrupt events for a PCI host unit and turns them into a single level-sensitive request to the CPU. Single-cycle event pulses from the descriptor engines and from the bus interface, plus the external INTA line, set bits in a 32-bit latched status register. Software clears a status bit by writing a one to it.

A 32-bit mask register selects which status bits may raise the request, and a one-bit global enable gates the request as a whole. The block also reports whether any unmasked source is pending and the index of the lowest-numbered one. An interrupt handler can therefore go straight to the source without scanning bits.

The registers sit behind a simple 32-bit port that writes in one cycle and reads combinationally.

Top module: `pci_irq_aggregator`

## Requirements
- R1: After reset the status, mask and enable registers read as zero, and `irqOut`, `pendValid` and `pendIdx` are all zero.
- R2: The status register is at offset 0x500, the mask at 0x504 and the enable at 0x508. Any other offset reads as zero, and a write to it changes none of the three registers.
- R3: A write to the status register clears every bit written as 1 and leaves every bit written as 0 unchanged. The change is visible after the write's clock edge.
- R4: A pulse on `descEvt[i]` at a clock edge sets status bit i, for i in {0..7, 9}. Pulses on `descEvt` bits 8 and 10..15 have no effect, and those status bits always read 0.
- R5: A pulse on `abortEvt` sets status bit 26.
- R6: `extIntA` passes through a two-flop synchronizer. Status bit 25 reads 1 from the third rising edge after the input goes high, and it is set again on every cycle that the synchronized input is high.
- R7: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set. Other bits cleared in that same write are still cleared.
- R8: `pendValid` is 1 exactly when status AND mask is non-zero.
- R9: `pendIdx` is the index of the lowest set bit of status AND mask, and 0 when nothing is pending.
- R10: `irqOut` is 1 exactly when bit 0 of the enable register is 1 and `pendValid` is 1. It is a level that stays high for as long as that holds.
- R11: The mask register stores and reads back all 32 bits. The enable register stores only bit 0, and its bits 31..1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| descEvt | input | 16 | Descriptor event pulses, one per status bit 15..0 |
| abortEvt | input | 1 | Bus abort event pulse |
| extIntA | input | 1 | External INTA level, asynchronous |
| irqOut | output | 1 | Level interrupt request to the CPU |
| pendValid | output | 1 | At least one unmasked source is pending |
| pendIdx | output | 5 | Lowest pending unmasked source index |

## Verification
An event setting a status bit and a software write clearing that same bit can land in the same clock cycle. The bench provokes this in two ways. It drives a descriptor pulse in the same cycle as a status write that also clears a second, already-set bit. It also issues a clear while the synchronized INTA input is still high. The result is judged by reading the status register afterwards: the colliding bit must stay set and the other cleared bit must be zero. The priority output is swept over every single-bit mask and every "from bit k upward" mask, and each result is compared with a lowest-set-bit search done in the bench.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2,
    SEL_GLOB = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrStat;
    logic    wrMask;
    logic    wrGlob;
    regSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] STAT_OFF = 12'h500,
  parameter logic [ADDR_W-1:0] MASK_OFF = 12'h504,
  parameter logic [ADDR_W-1:0] GLOB_OFF = 12'h508
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe
);

  regSel_e sel;

  always_comb begin
    if      (regAddr == STAT_OFF) sel = SEL_STAT;
    else if (regAddr == MASK_OFF) sel = SEL_MASK;
    else if (regAddr == GLOB_OFF) sel = SEL_GLOB;
    else                          sel = SEL_NONE;
  end

  always_comb begin
    strobe.rdSel  = sel;
    strobe.wrStat = regWrEn && (sel == SEL_STAT);
    strobe.wrMask = regWrEn && (sel == SEL_MASK);
    strobe.wrGlob = regWrEn && (sel == SEL_GLOB);
  end

  // R2: at most one register takes a write, and only when a write is requested
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrStat, strobe.wrMask, strobe.wrGlob}));
  p_write_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStat || strobe.wrMask || strobe.wrGlob) |-> regWrEn);

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter int              DESC_W      = 16,
  parameter int              EXT_BIT     = 25,
  parameter int              ABORT_BIT   = 26,
  parameter int              SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h060002FF,
  localparam int             IDX_W       = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DESC_W-1:0] descEvt,
  input  logic              abortEvt,
  input  logic              extIntA,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              pendValid,
  output logic [IDX_W-1:0]  pendIdx
);

  logic              extSync;
  logic [DATA_W-1:0] setVec;
  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] maskQ;
  logic              globQ;
  logic [DATA_W-1:0] pending;

  irq_agg_sync #(.STAGES(SYNC_STAGES)) i_extSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (extIntA),
    .syncOut (extSync)
  );

  // Per-bit event sources; bits outside IMPL_MASK are never set
  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_src
      logic descHit;
      if (b < DESC_W) begin : g_desc
        assign descHit = descEvt[b];
      end else begin : g_nodesc
        assign descHit = 1'b0;
      end
      assign setVec[b] = IMPL_MASK[b] &
                         (descHit | ((b == EXT_BIT) & extSync) | ((b == ABORT_BIT) & abortEvt));
    end
  endgenerate

  assign clrVec = strobe.wrStat ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrVec) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '0;
    else if (strobe.wrMask) maskQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              globQ <= 1'b0;
    else if (strobe.wrGlob) globQ <= wrData[0];
  end

  assign pending = statusQ & maskQ;

  // Lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    pendIdx   = '0;
    pendValid = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pendIdx   = IDX_W'(i);
        pendValid = 1'b1;
      end
    end
  end

  assign irqOut = globQ & pendValid;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_STAT: rdData = statusQ;
      SEL_MASK: rdData = maskQ;
      SEL_GLOB: rdData = {{(DATA_W-1){1'b0}}, globQ};
      default:  rdData = '0;
    endcase
  end

  // R7: any bit an event requested is set after the edge, whatever was written
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> (($past(setVec) & ~statusQ) == '0));
  // R3: bits written as one without a colliding event are clear afterwards
  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrStat |=> ((statusQ & $past(wrData) & ~$past(setVec)) == '0));
  // R6: synchronized INTA sets its bit one edge later
  p_ext_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    extSync |=> statusQ[EXT_BIT]);
  // R9: reported index is pending and nothing below it is
  p_idx_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> pending[pendIdx]);
  p_idx_lowest_r9: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> ((pending & ((DATA_W'(1) << pendIdx) - DATA_W'(1))) == '0));
  p_idx_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pendValid |-> (pendIdx == '0));

endmodule

// File: rtl/pci_irq_aggregator.sv
module pci_irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int DESC_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DESC_W-1:0] descEvt,
  input  logic              abortEvt,
  input  logic              extIntA,
  output logic              irqOut,
  output logic              pendValid,
  output logic [IDX_W-1:0]  pendIdx
);

  regStrobe_t strobe;

  irq_agg_ctrl #(
    .ADDR_W   (ADDR_W),
    .STAT_OFF (ADDR_W'(12'h500)),
    .MASK_OFF (ADDR_W'(12'h504)),
    .GLOB_OFF (ADDR_W'(12'h508))
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe)
  );

  irq_agg_datapath #(
    .DATA_W      (DATA_W),
    .DESC_W      (DESC_W),
    .EXT_BIT     (25),
    .ABORT_BIT   (26),
    .SYNC_STAGES (SYNC_STAGES),
    .IMPL_MASK   (DATA_W'(32'h060002FF))
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .descEvt   (descEvt),
    .abortEvt  (abortEvt),
    .extIntA   (extIntA),
    .rdData    (regRdData),
    .irqOut    (irqOut),
    .pendValid (pendValid),
    .pendIdx   (pendIdx)
  );

  // R10: the request is only raised for a pending unmasked source
  p_irq_needs_pending_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> pendValid);

endmodule

// File: tb/test_pci_irq_aggregator.sv
module test_pci_irq_aggregator;

  localparam logic [11:0] A_STAT = 12'h500;
  localparam logic [11:0] A_MASK = 12'h504;
  localparam logic [11:0] A_GLOB = 12'h508;
  localparam logic [31:0] IMPL   = 32'h060002FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] descEvt = '0;
  logic        abortEvt = 1'b0;
  logic        extIntA = 1'b0;
  logic        irqOut;
  logic        pendValid;
  logic [4:0]  pendIdx;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pci_irq_aggregator i_pci_irq_aggregator (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .descEvt(descEvt),
    .abortEvt(abortEvt), .extIntA(extIntA), .irqOut(irqOut),
    .pendValid(pendValid), .pendIdx(pendIdx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulse(input logic [15:0] dv, input logic ab);
    @(negedge clk);
    descEvt = dv; abortEvt = ab;
    @(negedge clk);
    descEvt = '0; abortEvt = 1'b0;
  endtask

  function automatic logic [5:0] lowest(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) lowest = 6'(i);
    if (v == 0) lowest = 6'd0;
  endfunction

  initial begin
    logic [31:0] d;
    logic [31:0] st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(A_STAT, d); check("R1 status", d, 0);
    rdReg(A_MASK, d); check("R1 mask", d, 0);
    rdReg(A_GLOB, d); check("R1 enable", d, 0);
    check("R1 outputs", {29'd0, irqOut, pendValid, 1'b0} | {27'd0, pendIdx}, 0);

    // R4 R3 sweep every descriptor input bit
    for (int i = 0; i < 16; i++) begin
      pulse(16'(1 << i), 1'b0);
      rdReg(A_STAT, d);
      check($sformatf("R4 desc bit %0d", i), d, (32'(1) << i) & IMPL);
      wrReg(A_STAT, 32'hFFFF_FFFF);
      rdReg(A_STAT, d);
      check($sformatf("R3 clear bit %0d", i), d, 0);
    end

    // R5 abort
    pulse(16'h0, 1'b1);
    rdReg(A_STAT, d); check("R5 abort bit", d, 32'h0400_0000);

    // R3 zero writes keep, ones clear selectively
    pulse(16'h02FF, 1'b0);
    st = 32'h0400_02FF;
    wrReg(A_STAT, 32'h0);
    rdReg(A_STAT, d); check("R3 write zero keeps", d, st);
    wrReg(A_STAT, 32'h0400_0055);
    st = st & ~32'h0400_0055;
    rdReg(A_STAT, d); check("R3 partial clear", d, st);
    wrReg(A_STAT, 32'hFFFF_FFFF);

    // R7 set wins, neighbour still cleared
    pulse(16'h0008, 1'b0);
    @(negedge clk);
    regAddr = A_STAT; regWrData = 32'h0000_000C; regWrEn = 1'b1; descEvt = 16'h0004;
    @(negedge clk);
    regWrEn = 1'b0; descEvt = '0;
    rdReg(A_STAT, d); check("R7 collision", d, 32'h0000_0004);
    wrReg(A_STAT, 32'hFFFF_FFFF);

    // R6 INTA synchronizer latency
    @(negedge clk);
    regAddr = A_STAT; extIntA = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 not yet after two edges", regRdData, 0);
    @(negedge clk);
    check("R6 set after three edges", regRdData, 32'h0200_0000);
    wrReg(A_STAT, 32'h0200_0000);
    rdReg(A_STAT, d); check("R7 INTA high beats clear", d, 32'h0200_0000);
    @(negedge clk); extIntA = 1'b0;
    repeat (4) @(negedge clk);
    wrReg(A_STAT, 32'hFFFF_FFFF);
    rdReg(A_STAT, d); check("R6 clears after INTA low", d, 0);

    // R8 R9 mask sweeps
    pulse(16'hFFFF, 1'b1);
    st = 32'h0400_02FF;
    rdReg(A_STAT, d); check("R4 all events", d, st);
    for (int k = 0; k < 32; k++) begin
      logic [31:0] m;
      m = 32'(1) << k;
      wrReg(A_MASK, m);
      #1;
      check($sformatf("R8 single mask %0d", k), {31'd0, pendValid}, {31'd0, |(st & m)});
      check($sformatf("R9 single mask %0d", k), {27'd0, pendIdx}, {26'd0, lowest(st & m)});
      m = ~((32'(1) << k) - 32'(1));
      wrReg(A_MASK, m);
      #1;
      check($sformatf("R8 upper mask %0d", k), {31'd0, pendValid}, {31'd0, |(st & m)});
      check($sformatf("R9 upper mask %0d", k), {27'd0, pendIdx}, {26'd0, lowest(st & m)});
    end

    // R11 readback widths
    wrReg(A_MASK, 32'hA5C3_0F96);
    rdReg(A_MASK, d); check("R11 mask readback", d, 32'hA5C3_0F96);
    wrReg(A_GLOB, 32'hFFFF_FFFF);
    rdReg(A_GLOB, d); check("R11 enable one bit", d, 32'h1);

    // R10 gating
    wrReg(A_MASK, 32'h0400_0000);
    #1 check("R10 enabled and pending", {31'd0, irqOut}, 1);
    wrReg(A_MASK, 32'h0);
    #1 check("R10 masked", {31'd0, irqOut}, 0);
    wrReg(A_MASK, 32'hFFFF_FFFF);
    wrReg(A_GLOB, 32'hFFFF_FFFE);
    #1 check("R10 globally disabled", {31'd0, irqOut}, 0);
    check("R10 pending still seen", {31'd0, pendValid}, 1);

    // R2 unmapped offsets
    wrReg(A_GLOB, 32'h1);
    wrReg(12'h50C, 32'hFFFF_FFFF);
    wrReg(12'h400, 32'h0);
    rdReg(12'h50C, d); check("R2 unmapped read", d, 0);
    rdReg(A_STAT, d); check("R2 status untouched", d, st);
    rdReg(A_MASK, d); check("R2 mask untouched", d, 32'hFFFF_FFFF);
    rdReg(A_GLOB, d); check("R2 enable untouched", d, 32'h1);
    #1 check("R10 level holds", {31'd0, irqOut}, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule